// File: doc/BRIEF.md
# Interrupt Trigger Configuration and Pending Latch

This block holds the trigger mode of every shared interrupt. A shared interrupt is one numbered 32 or above and below the implemented count. Each one is either edge-triggered or level-triggered. The block also holds the pending state that the interrupt input lines produce.

Software reaches the trigger modes through 32-bit configuration words. Each word gives every interrupt a 2-bit field. Only the upper bit of the field is stored: 1 means edge-triggered. The lower bit always reads as zero. A non-secure access made while security is enabled can only see and change interrupts whose group bit is 1.

The input lines are synchronous to the block clock. Each line is compared every cycle with a registered copy of itself. A rising line on an edge-triggered interrupt sets a pending latch, and that latch stays set until a clear strobe arrives. A level-triggered interrupt reports its registered level as pending. Priority handling and delivery to CPUs are handled elsewhere.

Top module: `itc_trigger_pend`

## Requirements
- R1: After reset, every interrupt is level-triggered, no pending latch is set, the stored line levels are 0, `pend_out` is all zero and every configuration word reads 0.
- R2: Configuration word index `w` covers interrupts `16*w` to `16*w+15`. The interrupt at offset `i` in that word uses bits `[2i+1:2i]`. Bit `2i+1` set to 1 means edge-triggered, and a write takes effect on the next clock edge.
- R3: The even bit of every field reads as 0, and the even bits of a written word are ignored.
- R4: A word whose first interrupt is below 32 (`w` < 2) or at or above `NUM_IRQ` reads 0, and writes to it change nothing.
- R5: When `acc_nonsec`=1 and `sec_dis`=0, a write leaves unchanged every interrupt whose `grp` bit is 0, and those interrupts read as 0. Interrupts whose `grp` bit is 1 read and write normally.
- R6: When `acc_nonsec`=0 or `sec_dis`=1, every interrupt of an in-range word can be read and written.
- R7: A write changes only the 16 interrupts of the addressed word.
- R8: A line that rises, on an edge-triggered interrupt, sets that interrupt's pending latch at the next clock edge. The latch stays set after the line falls.
- R9: For a level-triggered interrupt, `pend_out` equals the line level registered at the previous clock edge. A rise on such a line sets no latch.
- R10: A line that holds its level causes no event. A line held high after its latch is cleared does not set the latch again.
- R11: A `clr_pend` bit clears the pending latch of that interrupt at the next clock edge. If the same cycle has a rise on that edge-triggered line, the set wins.
- R12: Lines that change in the same cycle are each handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_dis | input | 1 | 1 = security disabled, so every access is treated as secure |
| grp | input | NUM_IRQ-32 | Group bit per shared interrupt (bit `k` belongs to interrupt `k+32`) |
| acc_wr | input | 1 | Configuration write strobe |
| acc_nonsec | input | 1 | 1 = the access is non-secure |
| acc_word | input | ADDR_W | Configuration word index (byte offset divided by 4) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_word`, combinational |
| line_in | input | NUM_IRQ-32 | Synchronous interrupt input lines (bit `k` belongs to interrupt `k+32`) |
| clr_pend | input | NUM_IRQ-32 | Strobe that clears the pending latch, one bit per interrupt |
| pend_out | output | NUM_IRQ-32 | Pending state per shared interrupt |

## Verification
The bench builds the block with `NUM_IRQ`=96 and `ADDR_W`=4. This gives four in-range words (2 to 5), two internal words (0 and 1) and ten words beyond the implemented count within a short address. With these values, both out-of-range cases, and the top of the address space, can be reached with a handful of accesses. The fixed group pattern gives four cases: alternating group bits in one word, the opposite alternation in the next, a word that is all group 1 and a word that is all group 0. Non-secure masking is therefore seen in each of its forms.

// File: rtl/itc_pkg.sv
// itc_pkg: constants and field packing helpers shared by the trigger
// configuration block. Assumes 32-bit configuration words, 2 bits per interrupt.
package itc_pkg;
    localparam int FIRST_SHARED = 32;
    localparam int IRQ_PER_WORD = 16;
    localparam int WORD_BITS    = 32;

    // Pull the upper bit of each 2-bit field into a 16-bit edge vector.
    function automatic logic [IRQ_PER_WORD-1:0] cfg_unpack(input logic [WORD_BITS-1:0] w);
        logic [IRQ_PER_WORD-1:0] r;
        for (int i = 0; i < IRQ_PER_WORD; i++) r[i] = w[2*i+1];
        return r;
    endfunction

    // Spread a 16-bit edge vector onto the upper bit of each field; lower bits stay 0.
    function automatic logic [WORD_BITS-1:0] cfg_pack(input logic [IRQ_PER_WORD-1:0] e);
        logic [WORD_BITS-1:0] r;
        r = '0;
        for (int i = 0; i < IRQ_PER_WORD; i++) r[2*i+1] = e[i];
        return r;
    endfunction
endpackage

// File: rtl/itc_cfg_port.sv
// itc_cfg_port: decodes a configuration word index, forms the access mask
// from group bits and security state, and packs the read data.
// Assumes NUM_IRQ is a multiple of 32 and at least 64.
module itc_cfg_port
    import itc_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        acc_word,
    input  logic                     acc_nonsec,
    input  logic                     sec_dis,
    input  logic [NUM_IRQ-33:0]      grp,
    input  logic [NUM_IRQ-33:0]      edge_q,
    output logic                     word_ok,
    output logic [ADDR_W-1:0]        slot_sel,
    output logic [IRQ_PER_WORD-1:0]  amask,
    output logic [WORD_BITS-1:0]     rdata
);
    localparam int NS         = NUM_IRQ - FIRST_SHARED;
    localparam int NSLOT      = NS / IRQ_PER_WORD;
    localparam int FIRST_WORD = FIRST_SHARED / IRQ_PER_WORD;
    localparam int END_WORD   = NUM_IRQ / IRQ_PER_WORD;

    logic [31:0]                         word_idx;
    logic [NSLOT-1:0][IRQ_PER_WORD-1:0]  grp_m;
    logic [NSLOT-1:0][IRQ_PER_WORD-1:0]  edge_m;
    logic [IRQ_PER_WORD-1:0]             grp16;
    logic [IRQ_PER_WORD-1:0]             edge16;
    logic                                full_access;

    // Range decode: only words holding shared, implemented interrupts are live.
    assign word_idx = 32'(acc_word);
    assign word_ok  = (word_idx >= 32'(FIRST_WORD)) && (word_idx < 32'(END_WORD));
    assign slot_sel = acc_word - ADDR_W'(FIRST_WORD);

    // Per-slot select of group and edge slices.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign grp_m[g]  = (slot_sel == ADDR_W'(g)) ? grp[g*IRQ_PER_WORD +: IRQ_PER_WORD]    : '0;
        assign edge_m[g] = (slot_sel == ADDR_W'(g)) ? edge_q[g*IRQ_PER_WORD +: IRQ_PER_WORD] : '0;
    end

    // OR-reduce the one-hot selected slices.
    always_comb begin
        grp16  = '0;
        edge16 = '0;
        for (int g = 0; g < NSLOT; g++) begin
            grp16  = grp16 | grp_m[g];
            edge16 = edge16 | edge_m[g];
        end
    end

    // Access mask: secure or security disabled sees everything, else group 1 only.
    assign full_access = !acc_nonsec || sec_dis;
    assign amask       = full_access ? '1 : grp16;

    // Read data: packed, masked edge bits, zero when out of range.
    assign rdata = word_ok ? cfg_pack(edge16 & amask) : '0;

    // R4: out-of-range words read as zero.
    a_r4_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ok |-> (rdata == '0));
    // R3: the lower bit of every field is zero on read.
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & 32'h5555_5555) == '0);
endmodule

// File: rtl/itc_edge_store.sv
// itc_edge_store: holds one edge-trigger bit per shared interrupt, in
// 16-bit slots, and applies masked configuration writes to the addressed slot.
// Assumes word_ok already excludes internal and unimplemented words.
module itc_edge_store
    import itc_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     word_ok,
    input  logic [ADDR_W-1:0]        slot_sel,
    input  logic [IRQ_PER_WORD-1:0]  amask,
    input  logic [WORD_BITS-1:0]     wdata,
    output logic [NUM_IRQ-33:0]      edge_q
);
    localparam int NS    = NUM_IRQ - FIRST_SHARED;
    localparam int NSLOT = NS / IRQ_PER_WORD;

    logic [IRQ_PER_WORD-1:0] wbits;

    // Keep only the odd-position bits of the written word.
    assign wbits = cfg_unpack(wdata);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [IRQ_PER_WORD-1:0] slot_q;
        logic                    hit;

        assign hit = wr_en && word_ok && (slot_sel == ADDR_W'(g));

        // Slot register: merge write bits under the access mask.
        always_ff @(posedge clk) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= (slot_q & ~amask) | (wbits & amask);
        end

        assign edge_q[g*IRQ_PER_WORD +: IRQ_PER_WORD] = slot_q;
    end

    // R4: writes to out-of-range words leave every edge bit untouched.
    a_r4_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_ok) |=> $stable(edge_q));
    // R7: with no write strobe the configuration holds.
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(edge_q));
endmodule

// File: rtl/itc_line_latch.sv
// itc_line_latch: registers the interrupt lines, detects rising edges and
// keeps the edge pending latches; level interrupts report the registered level.
// Assumes lines are synchronous to clk.
module itc_line_latch #(
    parameter int NS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] line_i,
    input  logic [NS-1:0] clr_i,
    input  logic [NS-1:0] edge_i,
    output logic [NS-1:0] pend_o
);
    logic [NS-1:0] lvl_q;
    logic [NS-1:0] pend_q;
    logic [NS-1:0] rise;
    logic [NS-1:0] set_v;

    // Change detection against the stored level: only a 0-to-1 change counts.
    assign rise  = line_i & ~lvl_q;
    assign set_v = rise & edge_i;

    // Stored level tracks the line each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= line_i;
    end

    // Pending latch: a set from an edge event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_v;
    end

    // Reported pending: latched edges plus the live level of level interrupts.
    assign pend_o = pend_q | (lvl_q & ~edge_i);

    // R8: an edge event sets its latch on the next edge.
    a_r8_edge_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));
    // R11: a clear without a concurrent set empties the latch.
    a_r11_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_v)) |=> ((pend_q & $past(clr_i & ~set_v)) == '0));
    // R10: a latch bit never rises without an edge event the cycle before.
    a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(set_v)) == '0));
endmodule

// File: rtl/itc_trigger_pend.sv
// itc_trigger_pend: top of the trigger configuration and pending latch.
// Connects the configuration port decode, the edge bitmap and the line latch.
// Assumes NUM_IRQ is a multiple of 32 and at least 64.
module itc_trigger_pend
    import itc_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_dis,
    input  logic [NUM_IRQ-33:0]   grp,
    input  logic                  acc_wr,
    input  logic                  acc_nonsec,
    input  logic [ADDR_W-1:0]     acc_word,
    input  logic [31:0]           acc_wdata,
    output logic [31:0]           acc_rdata,
    input  logic [NUM_IRQ-33:0]   line_in,
    input  logic [NUM_IRQ-33:0]   clr_pend,
    output logic [NUM_IRQ-33:0]   pend_out
);
    localparam int NS = NUM_IRQ - FIRST_SHARED;

    logic                    word_ok;
    logic [ADDR_W-1:0]       slot_sel;
    logic [IRQ_PER_WORD-1:0] amask;
    logic [NS-1:0]           edge_q;
    logic                    restricted;

    // Address decode, access mask and read packing.
    itc_cfg_port #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_word   (acc_word),
        .acc_nonsec (acc_nonsec),
        .sec_dis    (sec_dis),
        .grp        (grp),
        .edge_q     (edge_q),
        .word_ok    (word_ok),
        .slot_sel   (slot_sel),
        .amask      (amask),
        .rdata      (acc_rdata)
    );

    // Edge-trigger bitmap.
    itc_edge_store #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr),
        .word_ok  (word_ok),
        .slot_sel (slot_sel),
        .amask    (amask),
        .wdata    (acc_wdata),
        .edge_q   (edge_q)
    );

    // Line sampling and pending latches.
    itc_line_latch #(.NS(NS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_in),
        .clr_i  (clr_pend),
        .edge_i (edge_q),
        .pend_o (pend_out)
    );

    // Restricted access: non-secure while security is enabled.
    assign restricted = acc_nonsec && !sec_dis;

    // R5: a restricted write never changes a group-0 interrupt's trigger mode.
    a_r5_group0_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && restricted) |=> ((edge_q & ~$past(grp)) == ($past(edge_q) & ~$past(grp))));
endmodule

// File: tb/tb_itc_trigger_pend.sv
`timescale 1ns/1ps
module tb_itc_trigger_pend;
    localparam int NUM_IRQ = 96;
    localparam int ADDR_W  = 4;
    localparam int NS      = NUM_IRQ - 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_dis = 1'b0;
    logic [NS-1:0]     grp = 64'h0000_FFFF_5555_AAAA;
    logic              acc_wr = 1'b0;
    logic              acc_nonsec = 1'b0;
    logic [ADDR_W-1:0] acc_word = '0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic [NS-1:0]     line_in = '0;
    logic [NS-1:0]     clr_pend = '0;
    logic [NS-1:0]     pend_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    itc_trigger_pend #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .sec_dis(sec_dis), .grp(grp),
        .acc_wr(acc_wr), .acc_nonsec(acc_nonsec), .acc_word(acc_word),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .line_in(line_in), .clr_pend(clr_pend), .pend_out(pend_out)
    );

    typedef struct packed {
        logic        wr;
        logic        ns;
        logic [3:0]  word;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // Group pattern: irq32-47 odd offsets g1, irq48-63 even offsets g1,
    // irq64-79 all g1, irq80-95 all g0.
    localparam vec_t VEC [14] = '{
        '{1'b1, 1'b0, 4'd2, 32'hFFFF_FFFF, 32'hAAAA_AAAA}, // R2 R3 all edge, low bits 0
        '{1'b1, 1'b0, 4'd3, 32'h5555_5555, 32'h0000_0000}, // R3 even bits ignored
        '{1'b1, 1'b0, 4'd3, 32'h8000_0002, 32'h8000_0002}, // R2 field 0 and 15
        '{1'b1, 1'b1, 4'd2, 32'h0000_0000, 32'h0000_0000}, // R5 clears g1 only, g0 hidden
        '{1'b0, 1'b0, 4'd2, 32'h0000_0000, 32'h2222_2222}, // R5 R6 R7 g0 kept
        '{1'b1, 1'b1, 4'd4, 32'hFFFF_FFFF, 32'hAAAA_AAAA}, // R5 all g1 writable
        '{1'b1, 1'b1, 4'd5, 32'hFFFF_FFFF, 32'h0000_0000}, // R5 all g0 blocked
        '{1'b0, 1'b0, 4'd5, 32'h0000_0000, 32'h0000_0000}, // R5 confirm unchanged
        '{1'b0, 1'b1, 4'd3, 32'h0000_0000, 32'h0000_0002}, // R5 mixed visibility
        '{1'b1, 1'b0, 4'd1, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 internal word
        '{1'b1, 1'b0, 4'd6, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 beyond count
        '{1'b1, 1'b0, 4'd0, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 word zero
        '{1'b0, 1'b0, 4'd2, 32'h0000_0000, 32'h2222_2222}, // R4 R7 neighbours intact
        '{1'b0, 1'b0, 4'd5, 32'h0000_0000, 32'h0000_0000}  // R4 no aliasing
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic ns, input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        acc_nonsec = ns; acc_word = w; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic ns, input logic [3:0] w,
                            input logic [31:0] exp);
        acc_nonsec = ns; acc_word = w;
        #1;
        check(req, 64'(acc_rdata), 64'(exp));
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check("R1 pend after reset", 64'(pend_out), 64'h0);
        read_chk("R1 word2 after reset", 1'b0, 4'd2, 32'h0);
        read_chk("R1 word4 after reset", 1'b0, 4'd4, 32'h0);

        // Table of configuration accesses.
        for (int i = 0; i < 14; i++) begin
            if (VEC[i].wr) do_write(VEC[i].ns, VEC[i].word, VEC[i].data);
            read_chk($sformatf("table vector %0d", i), VEC[i].ns, VEC[i].word, VEC[i].exp);
        end

        // R6: security disabled lets non-secure reach group 0 (irq80, irq81).
        sec_dis = 1'b1;
        do_write(1'b1, 4'd5, 32'h0000_000A);
        read_chk("R6 sec_dis nonsec read", 1'b1, 4'd5, 32'h0000_000A);
        sec_dis = 1'b0;
        read_chk("R5 g0 hidden again", 1'b1, 4'd5, 32'h0);

        // Edge config now: idx0 (irq32) edge, idx1 level, idx2 edge, idx3 level, idx32 edge.
        @(negedge clk); line_in[0] = 1'b1;
        step(); check("R8 edge latch set", 64'(pend_out[0]), 64'h1);
        line_in[0] = 1'b0;
        step(); check("R8 latch holds after fall", 64'(pend_out[0]), 64'h1);
        clr_pend[0] = 1'b1;
        @(negedge clk); clr_pend[0] = 1'b0; #1;
        check("R11 clear strobe", 64'(pend_out[0]), 64'h0);

        line_in[0] = 1'b1;
        step(); check("R8 second rise", 64'(pend_out[0]), 64'h1);
        clr_pend[0] = 1'b1;
        @(negedge clk); clr_pend[0] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R10 held line no relatch", 64'(pend_out[0]), 64'h0);
        line_in[0] = 1'b0;

        @(negedge clk); line_in[1] = 1'b1; #1;
        check("R9 level not yet registered", 64'(pend_out[1]), 64'h0);
        step(); check("R9 level pending", 64'(pend_out[1]), 64'h1);
        line_in[1] = 1'b0;
        step(); check("R9 level follows fall", 64'(pend_out[1]), 64'h0);

        line_in[2] = 1'b1; line_in[3] = 1'b1; line_in[32] = 1'b1;
        step(); check("R12 simultaneous rises", 64'({pend_out[32], pend_out[3], pend_out[2]}), 64'h7);
        line_in[2] = 1'b0; line_in[3] = 1'b0; line_in[32] = 1'b0;
        step(); check("R12 simultaneous falls", 64'({pend_out[32], pend_out[3], pend_out[2]}), 64'h5);
        clr_pend[2] = 1'b1; clr_pend[32] = 1'b1;
        @(negedge clk); clr_pend = '0; #1;
        check("R11 multi clear", 64'({pend_out[32], pend_out[2]}), 64'h0);

        line_in[2] = 1'b1; clr_pend[2] = 1'b1;
        @(negedge clk); clr_pend[2] = 1'b0; #1;
        check("R11 set wins over clear", 64'(pend_out[2]), 64'h1);
        line_in[2] = 1'b0;
        step();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule